// File: doc/BRIEF.md
# Audio Interface Master Clock Generator

This block produces every timing signal an audio serial interface needs in master mode from a single system clock. All outputs are registered levels or one-cycle strobes in the system clock domain. The system timebase advances on a tick chosen by a select input, either the master-clock tick or the tick of a frequency-locked loop. Each tick steps the ADC and DAC frame counters, the bit-clock divider, a general-purpose output-clock divider and a slow timeout divider.

The ADC and DAC sample rates are each set by a 3-bit code that picks a ratio of the frame base. The frame base is 256 system ticks in normal mode and 272 in USB mode, so a 12 MHz reference gives close to 44.1 kHz. Fractional ratios give whole tick counts, because every product of base and ratio is an even integer.

The bit clock is held low and its phase is restarted at every frame start of the faster path. This keeps the bit-clock edges and both frame-clock edges in one repeatable relation. A configuration change is held off until the next frame start of the currently faster path. At that point every counter restarts together.

Top module: `aif_clkgen`

## Requirements
- R1: The system tick is `mclk_tick` when `src_sel`=0 and `fll_tick` when `src_sel`=1. No output changes in a cycle after which no selected tick occurred.
- R2: The rate code c (0..7) selects a ratio of 1, 1.5, 2, 3, 4, 5.5, 6 or 6 (code 7 behaves as 6). In normal mode (`usb_mode`=0) the frame period is 256 × ratio system ticks.
- R3: With `usb_mode`=1 the frame base is 272, so the period is 272 × ratio system ticks.
- R4: `adc_fs`/`dac_fs` are one-cycle strobes, once per frame. The matching frame clock rises with the strobe, is high for the first half of the frame and is low for the second half.
- R5: `bclk` toggles every max(`bclk_half`,1) ticks. It is forced low with its phase restarted at each frame start of the reference path. The reference path is the DAC path under loopback or when the DAC period ≤ the ADC period, and the ADC path otherwise.
- R6: With `loopback`=1, `adc_lrclk` and `adc_fs` are the DAC frame clock and DAC strobe.
- R7: `opclk` toggles every max(`op_div`,1) ticks, starting low at each restart.
- R8: With `to_en`=1, `to_tick` pulses for one cycle every 64·2^`to_rate` ticks. With `to_en`=0 it stays low.
- R9: After reset the strobes, `bclk`, `opclk` and `to_tick` are 0, and both frame clocks are 1.
- R10: A configuration change takes effect at the next frame start of the old reference path. At that start every counter restarts, so each path's next strobe comes exactly one new period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Tick source select: 0 master clock, 1 FLL |
| mclk_tick | input | 1 | Master-clock tick enable |
| fll_tick | input | 1 | FLL tick enable |
| usb_mode | input | 1 | Frame base 272 instead of 256 |
| loopback | input | 1 | ADC frame timing follows DAC |
| adc_rate | input | 3 | ADC rate code |
| dac_rate | input | 3 | DAC rate code |
| bclk_half | input | BDIV_W | Ticks per bit-clock half period |
| op_div | input | OPDIV_W | Ticks per output-clock half period |
| to_en | input | 1 | Timeout tick enable |
| to_rate | input | TO_RATE_W | Timeout period exponent |
| sys_tick | output | 1 | Selected system tick |
| adc_fs | output | 1 | ADC frame-start strobe |
| dac_fs | output | 1 | DAC frame-start strobe |
| bclk | output | 1 | Bit clock |
| adc_lrclk | output | 1 | ADC frame clock |
| dac_lrclk | output | 1 | DAC frame clock |
| opclk | output | 1 | General-purpose output clock |
| to_tick | output | 1 | Timeout tick |

## Verification
Every output is registered. After the restart point t0, the first event of a divider with limit N is seen N ticks later: a strobe after the full period, a frame-clock fall after half the period, the first rise of `bclk` or `opclk` after their half values, and the first timeout pulse after its period. The bench drives at the falling edge and counts falling edges from the cycle in which the old reference strobe appears. It compares the index of the first occurrence of each event with these values. With alternating FLL ticks, every interval doubles.

// File: rtl/aif_clk_pkg.sv
package aif_clk_pkg;

    localparam int unsigned NORM_BASE = 256;
    localparam int unsigned USB_BASE  = 272;

    typedef struct packed {
        logic       usb;
        logic       lb;
        logic [2:0] adc_code;
        logic [2:0] dac_code;
    } rate_cfg_t;

    // ratio expressed in half steps
    function automatic int unsigned half_steps(input logic [2:0] c);
        case (c)
            3'd0:    return 2;
            3'd1:    return 3;
            3'd2:    return 4;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 11;
            default: return 12;
        endcase
    endfunction

    function automatic int unsigned frame_period(input logic usb, input logic [2:0] c);
        int unsigned base;
        base = usb ? USB_BASE : NORM_BASE;
        return (base * half_steps(c)) / 2;
    endfunction

endpackage

// File: rtl/aif_frame_div.sv
module aif_frame_div #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] period,
    output logic             wrap,
    output logic             fs_o,
    output logic             lr_o
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nxt;

    assign wrap = tick && (cnt >= period - CNT_W'(1));
    assign nxt  = cnt + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            fs_o <= 1'b0;
            lr_o <= 1'b1;
        end else if (tick) begin
            if (wrap || restart) begin
                cnt  <= '0;
                fs_o <= wrap;
                lr_o <= 1'b1;
            end else begin
                cnt  <= nxt;
                fs_o <= 1'b0;
                lr_o <= (nxt < (period >> 1));
            end
        end else begin
            fs_o <= 1'b0;
        end
    end

    // R4
    fs_single_chk: assert property (@(posedge clk) disable iff (rst) fs_o |=> !fs_o);
    // R4
    fs_lr_high_chk: assert property (@(posedge clk) disable iff (rst) fs_o |-> lr_o);
    // R4
    lr_rise_at_fs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lr_o) |-> (fs_o || $past(restart)));

endmodule

// File: rtl/aif_bclk_div.sv
module aif_bclk_div #(
    parameter int BDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              sync,
    input  logic [BDIV_W-1:0] half,
    output logic              bclk_o
);
    logic [BDIV_W-1:0] cnt;
    logic [BDIV_W-1:0] lim;
    logic              sync_q;

    assign lim = (half == '0) ? BDIV_W'(1) : half;

    always_ff @(posedge clk) begin
        if (rst || (tick && sync)) begin
            cnt    <= '0;
            bclk_o <= 1'b0;
        end else if (tick) begin
            if (cnt >= lim - BDIV_W'(1)) begin
                cnt    <= '0;
                bclk_o <= ~bclk_o;
            end else begin
                cnt <= cnt + BDIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= tick && sync;
    end

    // R5
    bclk_low_at_frame_chk: assert property (@(posedge clk) disable iff (rst) sync_q |-> !bclk_o);
    // R1
    bclk_hold_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(bclk_o));

endmodule

// File: rtl/aif_aux_div.sv
module aif_aux_div #(
    parameter int OPDIV_W   = 8,
    parameter int TO_BASE   = 64,
    parameter int TO_RATE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 restart,
    input  logic [OPDIV_W-1:0]   op_div,
    input  logic                 to_en,
    input  logic [TO_RATE_W-1:0] to_rate,
    output logic                 opclk_o,
    output logic                 to_tick_o
);
    localparam int TO_W = $clog2(TO_BASE) + (2 ** TO_RATE_W);

    logic [OPDIV_W-1:0] op_cnt;
    logic [OPDIV_W-1:0] op_lim;
    logic [TO_W-1:0]    to_cnt;
    logic [TO_W-1:0]    to_lim;

    assign op_lim = (op_div == '0) ? OPDIV_W'(1) : op_div;
    assign to_lim = TO_W'(TO_BASE) << to_rate;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            op_cnt  <= '0;
            opclk_o <= 1'b0;
        end else if (tick) begin
            if (op_cnt >= op_lim - OPDIV_W'(1)) begin
                op_cnt  <= '0;
                opclk_o <= ~opclk_o;
            end else begin
                op_cnt <= op_cnt + OPDIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !to_en) begin
            to_cnt    <= '0;
            to_tick_o <= 1'b0;
        end else if (tick) begin
            if (to_cnt >= to_lim - TO_W'(1)) begin
                to_cnt    <= '0;
                to_tick_o <= 1'b1;
            end else begin
                to_cnt    <= to_cnt + TO_W'(1);
                to_tick_o <= 1'b0;
            end
        end else begin
            to_tick_o <= 1'b0;
        end
    end

    // R8
    to_pulse_chk: assert property (@(posedge clk) disable iff (rst) to_tick_o |=> !to_tick_o);
    // R8
    to_off_chk: assert property (@(posedge clk) disable iff (rst) !to_en |=> !to_tick_o);
    // R1
    opclk_hold_chk: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(opclk_o));

endmodule

// File: rtl/aif_clkgen.sv
module aif_clkgen
    import aif_clk_pkg::*;
#(
    parameter int CNT_W     = 11,
    parameter int BDIV_W    = 8,
    parameter int OPDIV_W   = 8,
    parameter int TO_BASE   = 64,
    parameter int TO_RATE_W = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 src_sel,
    input  logic                 mclk_tick,
    input  logic                 fll_tick,
    input  logic                 usb_mode,
    input  logic                 loopback,
    input  logic [2:0]           adc_rate,
    input  logic [2:0]           dac_rate,
    input  logic [BDIV_W-1:0]    bclk_half,
    input  logic [OPDIV_W-1:0]   op_div,
    input  logic                 to_en,
    input  logic [TO_RATE_W-1:0] to_rate,
    output logic                 sys_tick,
    output logic                 adc_fs,
    output logic                 dac_fs,
    output logic                 bclk,
    output logic                 adc_lrclk,
    output logic                 dac_lrclk,
    output logic                 opclk,
    output logic                 to_tick
);
    rate_cfg_t            cfg_in, act;
    logic [BDIV_W-1:0]    act_bh;
    logic [OPDIV_W-1:0]   act_op;
    logic                 act_to_en;
    logic [TO_RATE_W-1:0] act_to_rate;

    logic [CNT_W-1:0] adc_p, dac_p;
    logic adc_wrap, dac_wrap, ref_dac, ref_wrap, pend, restart;
    logic adc_fs_r, adc_lr_r, dac_fs_r, dac_lr_r;

    assign sys_tick = src_sel ? fll_tick : mclk_tick;

    assign cfg_in = '{usb: usb_mode, lb: loopback, adc_code: adc_rate, dac_code: dac_rate};

    assign pend = (cfg_in != act) || (bclk_half != act_bh) || (op_div != act_op)
               || (to_en != act_to_en) || (to_rate != act_to_rate);

    assign adc_p    = CNT_W'(frame_period(act.usb, act.adc_code));
    assign dac_p    = CNT_W'(frame_period(act.usb, act.dac_code));
    assign ref_dac  = act.lb || (dac_p <= adc_p);
    assign ref_wrap = ref_dac ? dac_wrap : adc_wrap;
    assign restart  = pend && ref_wrap;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            act         <= cfg_in;
            act_bh      <= bclk_half;
            act_op      <= op_div;
            act_to_en   <= to_en;
            act_to_rate <= to_rate;
        end
    end

    aif_frame_div #(.CNT_W(CNT_W)) adc_div_i (
        .clk(clk), .rst(rst), .tick(sys_tick), .restart(restart), .period(adc_p),
        .wrap(adc_wrap), .fs_o(adc_fs_r), .lr_o(adc_lr_r)
    );

    aif_frame_div #(.CNT_W(CNT_W)) dac_div_i (
        .clk(clk), .rst(rst), .tick(sys_tick), .restart(restart), .period(dac_p),
        .wrap(dac_wrap), .fs_o(dac_fs_r), .lr_o(dac_lr_r)
    );

    aif_bclk_div #(.BDIV_W(BDIV_W)) bclk_div_i (
        .clk(clk), .rst(rst), .tick(sys_tick), .sync(ref_wrap), .half(act_bh),
        .bclk_o(bclk)
    );

    aif_aux_div #(.OPDIV_W(OPDIV_W), .TO_BASE(TO_BASE), .TO_RATE_W(TO_RATE_W)) aux_i (
        .clk(clk), .rst(rst), .tick(sys_tick), .restart(restart),
        .op_div(act_op), .to_en(act_to_en), .to_rate(act_to_rate),
        .opclk_o(opclk), .to_tick_o(to_tick)
    );

    assign dac_fs    = dac_fs_r;
    assign dac_lrclk = dac_lr_r;
    assign adc_fs    = act.lb ? dac_fs_r : adc_fs_r;
    assign adc_lrclk = act.lb ? dac_lr_r : adc_lr_r;

    // R10
    restart_on_tick_chk: assert property (@(posedge clk) disable iff (rst) restart |-> sys_tick);
    // R10
    cfg_settled_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (act == $past(cfg_in)));

endmodule

// File: tb/aif_clkgen_tb_top.sv
module aif_clkgen_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic src_sel = 1'b0, mclk_tick = 1'b1, fll_tick = 1'b0;
    logic usb_mode = 1'b0, loopback = 1'b0;
    logic [2:0] adc_rate = 3'd0, dac_rate = 3'd0;
    logic [7:0] bclk_half = 8'd4, op_div = 8'd3;
    logic to_en = 1'b0;
    logic [1:0] to_rate = 2'd0;
    logic sys_tick, adc_fs, dac_fs, bclk, adc_lrclk, dac_lrclk, opclk, to_tick;

    int checks = 0, errors = 0;
    bit done = 0;
    bit fll_run = 0;
    int cur_ap = 256, cur_dp = 256;
    bit cur_lb = 0;

    always #5 clk = ~clk;

    aif_clkgen dut_i (
        .clk(clk), .rst(rst), .src_sel(src_sel), .mclk_tick(mclk_tick), .fll_tick(fll_tick),
        .usb_mode(usb_mode), .loopback(loopback), .adc_rate(adc_rate), .dac_rate(dac_rate),
        .bclk_half(bclk_half), .op_div(op_div), .to_en(to_en), .to_rate(to_rate),
        .sys_tick(sys_tick), .adc_fs(adc_fs), .dac_fs(dac_fs), .bclk(bclk),
        .adc_lrclk(adc_lrclk), .dac_lrclk(dac_lrclk), .opclk(opclk), .to_tick(to_tick)
    );

    // usb, lb, adc code, dac code, bclk_half, op_div, to_en, to_rate, exp adc p, exp dac p, exp to
    typedef struct packed {
        logic usb; logic lb; logic [2:0] ac; logic [2:0] dc;
        logic [7:0] bh; logic [7:0] op; logic toen; logic [1:0] tor;
        int ap; int dp; int tp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 3'd1, 3'd0, 8'd4, 8'd3, 1'b1, 2'd0, 384,  256,  64},
        '{1'b0, 1'b0, 3'd2, 3'd3, 8'd2, 8'd5, 1'b1, 2'd1, 512,  768,  128},
        '{1'b0, 1'b0, 3'd5, 3'd6, 8'd8, 8'd2, 1'b0, 2'd0, 1408, 1536, 0},
        '{1'b1, 1'b0, 3'd0, 3'd1, 8'd4, 8'd3, 1'b1, 2'd2, 272,  408,  256},
        '{1'b1, 1'b0, 3'd5, 3'd4, 8'd1, 8'd1, 1'b1, 2'd3, 1496, 1088, 512},
        '{1'b1, 1'b0, 3'd7, 3'd6, 8'd2, 8'd7, 1'b0, 2'd0, 1632, 1632, 0},
        '{1'b0, 1'b1, 3'd4, 3'd0, 8'd4, 8'd3, 1'b1, 2'd0, 256,  256,  64},
        '{1'b0, 1'b0, 3'd7, 3'd2, 8'd0, 8'd0, 1'b1, 2'd1, 1536, 512,  128}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        bit ref_dac;
        int n, f_afs, f_dfs, f_alr, f_dlr, f_bclk, f_op, f_to, win;
        int exp_bh, exp_op;
        v = VECS[i];
        ref_dac = cur_lb || (cur_dp <= cur_ap);
        @(negedge clk);
        usb_mode = v.usb; loopback = v.lb; adc_rate = v.ac; dac_rate = v.dc;
        bclk_half = v.bh; op_div = v.op; to_en = v.toen; to_rate = v.tor;
        // R10: restart happens at the next frame start of the old reference path
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(ref_dac ? dac_fs : adc_fs) && n < 4000);
        chk("R10", "restart reached", int'(n <= (ref_dac ? cur_dp : cur_ap) + 1), 1);
        chk("R5", "bclk low at restart", int'(bclk), 0);
        chk("R4", "both frame clocks high at restart", int'(adc_lrclk && dac_lrclk), 1);
        f_afs = 0; f_dfs = 0; f_alr = 0; f_dlr = 0; f_bclk = 0; f_op = 0; f_to = 0;
        win = ((v.ap > v.dp) ? v.ap : v.dp) + 4;
        for (int k = 1; k <= win; k++) begin
            @(negedge clk);
            if (adc_fs && f_afs == 0) f_afs = k;
            if (dac_fs && f_dfs == 0) f_dfs = k;
            if (!adc_lrclk && f_alr == 0) f_alr = k;
            if (!dac_lrclk && f_dlr == 0) f_dlr = k;
            if (bclk && f_bclk == 0) f_bclk = k;
            if (opclk && f_op == 0) f_op = k;
            if (to_tick && f_to == 0) f_to = k;
        end
        exp_bh = (v.bh == 0) ? 1 : int'(v.bh);
        exp_op = (v.op == 0) ? 1 : int'(v.op);
        // R2 R3 R6 R10: each path restarts and strobes one new period later
        chk(v.lb ? "R6" : (v.usb ? "R3" : "R2"), "adc period", f_afs, v.ap);
        chk(v.usb ? "R3" : "R2", "dac period", f_dfs, v.dp);
        chk("R4", "adc lrclk high half", f_alr, v.ap / 2);
        chk("R4", "dac lrclk high half", f_dlr, v.dp / 2);
        chk("R5", "bclk first rise", f_bclk, exp_bh);
        chk("R7", "opclk first rise", f_op, exp_op);
        chk("R8", "timeout first tick", f_to, v.toen ? v.tp : 0);
        cur_ap = v.ap; cur_dp = v.dp; cur_lb = v.lb;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "adc_fs", int'(adc_fs), 0);
        chk("R9", "dac_fs", int'(dac_fs), 0);
        chk("R9", "bclk", int'(bclk), 0);
        chk("R9", "opclk", int'(opclk), 0);
        chk("R9", "to_tick", int'(to_tick), 0);
        chk("R9", "lrclks", int'(adc_lrclk && dac_lrclk), 1);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) run_vec(i);

        // R1: FLL tick at half rate doubles the frame interval
        @(negedge clk);
        src_sel = 1'b1; fll_run = 1'b1;
        begin
            int n, t1, t2;
            n = 0; t1 = 0; t2 = 0;
            while (t2 == 0 && n < 5000) begin
                @(negedge clk);
                n++;
                if (dac_fs) begin
                    if (t1 == 0) t1 = n; else t2 = n;
                end
            end
            chk("R1", "dac interval on FLL ticks", t2 - t1, 2 * cur_dp);
        end
        // R1: no selected tick means frozen outputs
        @(negedge clk);
        fll_run = 1'b0;
        @(negedge clk);
        fll_tick = 1'b0;
        @(negedge clk);
        begin
            logic b0, o0, l0;
            int moved;
            b0 = bclk; o0 = opclk; l0 = dac_lrclk; moved = 0;
            for (int k = 0; k < 700; k++) begin
                @(negedge clk);
                if (bclk != b0 || opclk != o0 || dac_lrclk != l0 || dac_fs || adc_fs || to_tick)
                    moved++;
            end
            chk("R1", "outputs frozen without tick", moved, 0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(negedge clk) begin
        if (fll_run) fll_tick <= ~fll_tick;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule